// File: doc/BRIEF.md
# Serially Configured Two-Level Logic Array

This block is a small sum-of-products logic array whose entire function is set by a string of switch bits. Four logic inputs feed an AND plane of four product rows. In each row, every input has one switch for its true form and one for its complement. An OR plane then gathers a chosen set of rows into each of the two outputs. The array itself holds no state: the outputs follow the inputs combinationally through the active configuration.

The switch string is 40 bits long and is loaded one bit per clock while a shift enable is high. Loading only fills a staging register. A separate commit strobe copies the staging register into the active register in one clock. The logic therefore never runs on a half-loaded string. A new string can be staged and committed at any time to turn the same hardware into a different function.

Top module: `cfg_logic_array`

## Requirements
- R1: While reset is asserted, and after it is released until the first commit, the active configuration is all zeros and both outputs are 0 for every input value.
- R2: With the shift enable high, one configuration bit is taken per clock, most significant first. After 40 shifts, the first bit shifted in sits at bit 39. The string holds row 0 first, then rows 1 to 3, with 10 bits per row. Within a row the bits come in this order: input 0 true, input 0 complement, input 1 true, input 1 complement, and so on up to input 3 complement, then the select bit for output 0, then the select bit for output 1. A bit value of 1 closes the switch.
- R3: A staged string has no effect on the outputs until a commit strobe. After the commit strobe is sampled at a clock edge, the outputs follow the new string.
- R4: A row's product is the AND of every literal whose switch is closed in that row.
- R5: A row whose only closed AND switch is the complement of input 0 yields the inverse of input 0.
- R6: Each output is the OR of the products of the rows whose select bit for that output is 1. The input pins are numbered so that input i is data bit i, and output j is data bit j.
- R7: A row with no AND switch closed yields 0, even when it is selected onto an output.
- R8: A row that closes both the true and the complement switch of the same input yields 0 for every input value. This is normal behaviour and is not flagged.
- R9: Committing a different string changes the realised function with no other action.
- R10: When the shift enable and the commit strobe are both high in the same cycle, the active register takes the staging contents from before that cycle's shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgBit | input | 1 | Serial configuration data |
| cfgShift | input | 1 | Shifts cfgBit into the staging register |
| cfgCommit | input | 1 | Copies the staging register into the active register |
| dataIn | input | 4 | Logic inputs, bit i is input i |
| dataOut | output | 2 | Logic outputs, bit j is output j |

## Verification
The bench targets the rows that must not contribute. An empty row selected onto both outputs is loaded, and if the design computed a plain AND over an empty set, that output would be stuck at 1. A row that closes both polarities of one input is driven with that input at each value; a design that let one polarity override the other would let the row fire. A full string is staged without a commit, and a design that exposed the staging register would change its outputs early. Shift and commit are then raised in the same cycle: a design that committed the post-shift value would realise the string shifted by one bit, which shows up as a wrong output for an all-zero input. The remaining checks cover reset, a reset in the middle of operation, and three different strings applied to several input patterns.

// File: rtl/cfg_array_pkg.sv
package cfg_array_pkg;

  localparam int DEF_NUM_IN   = 4;
  localparam int DEF_NUM_OUT  = 2;
  localparam int DEF_NUM_ROWS = 4;

  // Strobes handed from control to the configuration datapath
  typedef struct packed {
    logic shift;
    logic commit;
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_array_ctrl.sv
module cfg_array_ctrl
  import cfg_array_pkg::*;
(
  input  logic       shiftReq,
  input  logic       commitReq,
  output cfgStrobe_t strobe
);

  always_comb begin
    strobe.shift  = shiftReq;
    strobe.commit = commitReq;
  end

endmodule

// File: rtl/cfg_array_store.sv
module cfg_array_store
  import cfg_array_pkg::*;
#(
  parameter int CFG_BITS = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  cfgStrobe_t          strobe,
  output logic [CFG_BITS-1:0] activeCfg
);

  logic [CFG_BITS-1:0] stageQ;
  logic [CFG_BITS-1:0] shadowQ;

  // Staging register, MSB-first serial fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stageQ <= '0;
    else if (strobe.shift)
      stageQ <= {stageQ[CFG_BITS-2:0], serialIn};
  end

  // Active register: atomic copy of the pre-edge staging contents
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shadowQ <= '0;
    else if (strobe.commit)
      shadowQ <= stageQ;
  end

  assign activeCfg = shadowQ;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> shadowQ == '0);

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> stageQ[0] == $past(serialIn));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> stageQ[CFG_BITS-1:1] == $past(stageQ[CFG_BITS-2:0]));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(shadowQ));

  // R10
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> shadowQ == $past(stageQ));

endmodule

// File: rtl/cfg_array_planes.sv
module cfg_array_planes #(
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 2,
  parameter int NUM_ROWS = 4,
  localparam int ROW_BITS = 2 * NUM_IN + NUM_OUT,
  localparam int CFG_BITS = ROW_BITS * NUM_ROWS
) (
  input  logic [CFG_BITS-1:0] cfgWord,
  input  logic [NUM_IN-1:0]   dataIn,
  output logic [NUM_OUT-1:0]  dataOut
);

  logic [NUM_IN-1:0]   trueSw [NUM_ROWS];
  logic [NUM_IN-1:0]   compSw [NUM_ROWS];
  logic [NUM_OUT-1:0]  orSel  [NUM_ROWS];
  logic [NUM_ROWS-1:0] prodTerm;

  // Field decode: row 0 at the top, per input true then complement, then selects
  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        trueSw[r][i] = cfgWord[CFG_BITS-1 - r*ROW_BITS - 2*i];
        compSw[r][i] = cfgWord[CFG_BITS-2 - r*ROW_BITS - 2*i];
      end
      for (int j = 0; j < NUM_OUT; j++)
        orSel[r][j] = cfgWord[CFG_BITS-1 - r*ROW_BITS - 2*NUM_IN - j];
    end
  end

  // AND plane: an empty row is forced low
  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      prodTerm[r] = (|trueSw[r]) | (|compSw[r]);
      for (int i = 0; i < NUM_IN; i++) begin
        if (trueSw[r][i] && !dataIn[i]) prodTerm[r] = 1'b0;
        if (compSw[r][i] &&  dataIn[i]) prodTerm[r] = 1'b0;
      end
    end
  end

  // OR plane
  always_comb begin
    for (int j = 0; j < NUM_OUT; j++) begin
      dataOut[j] = 1'b0;
      for (int r = 0; r < NUM_ROWS; r++)
        if (orSel[r][j]) dataOut[j] = dataOut[j] | prodTerm[r];
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      // R7
      if (trueSw[r] == '0 && compSw[r] == '0)
        empty_row_low_chk: assert (prodTerm[r] == 1'b0);
      // R8
      if ((trueSw[r] & compSw[r]) != '0)
        conflict_row_low_chk: assert (prodTerm[r] == 1'b0);
    end
  end

endmodule

// File: rtl/cfg_logic_array.sv
module cfg_logic_array
  import cfg_array_pkg::*;
#(
  parameter int NUM_IN   = DEF_NUM_IN,
  parameter int NUM_OUT  = DEF_NUM_OUT,
  parameter int NUM_ROWS = DEF_NUM_ROWS,
  localparam int ROW_BITS = 2 * NUM_IN + NUM_OUT,
  localparam int CFG_BITS = ROW_BITS * NUM_ROWS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgBit,
  input  logic               cfgShift,
  input  logic               cfgCommit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);

  cfgStrobe_t          strobe;
  logic [CFG_BITS-1:0] activeCfg;

  cfg_array_ctrl uCtrl (
    .shiftReq  (cfgShift),
    .commitReq (cfgCommit),
    .strobe    (strobe)
  );

  cfg_array_store #(.CFG_BITS(CFG_BITS)) uStore (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (cfgBit),
    .strobe    (strobe),
    .activeCfg (activeCfg)
  );

  cfg_array_planes #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .NUM_ROWS (NUM_ROWS)
  ) uPlanes (
    .cfgWord (activeCfg),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tb_cfg_logic_array.sv
module tb_cfg_logic_array;

  localparam int CFGW = 40;

  // Row layout: [in0 t,c][in1 t,c][in2 t,c][in3 t,c][sel out0, sel out1]
  localparam logic [CFGW-1:0] CFG_A = {10'b01_00_00_00_10, 10'b0, 10'b0, 10'b0};
  localparam logic [CFGW-1:0] CFG_B = {10'b00_00_00_00_11, 10'b10_01_01_10_11,
                                       10'b00_00_10_00_01, 10'b00_11_00_00_10};
  localparam logic [CFGW-1:0] CFG_C = {10'b10_10_00_00_10, 10'b00_00_10_10_10,
                                       10'b01_01_00_00_01, 10'b10_00_00_01_01};

  typedef struct packed {
    logic [CFGW-1:0] cfg;
    logic [3:0]      din;
    logic [1:0]      exp;
    logic [3:0]      req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{CFG_A, 4'b0000, 2'b01, 4'd5},  // R5
    '{CFG_A, 4'b1110, 2'b01, 4'd5},  // R5
    '{CFG_A, 4'b0001, 2'b00, 4'd5},  // R5
    '{CFG_A, 4'b1111, 2'b00, 4'd5},  // R5
    '{CFG_B, 4'b1001, 2'b11, 4'd4},  // R4 with R6
    '{CFG_B, 4'b0000, 2'b00, 4'd7},  // R7 empty row on both outputs
    '{CFG_B, 4'b0100, 2'b10, 4'd6},  // R6
    '{CFG_B, 4'b0010, 2'b00, 4'd8},  // R8 conflict row, input high
    '{CFG_B, 4'b1101, 2'b10, 4'd4},  // R4
    '{CFG_B, 4'b1111, 2'b10, 4'd6},  // R6
    '{CFG_C, 4'b0011, 2'b11, 4'd9},  // R9
    '{CFG_C, 4'b1100, 2'b11, 4'd6},  // R6
    '{CFG_C, 4'b1000, 2'b10, 4'd9},  // R9
    '{CFG_C, 4'b1001, 2'b00, 4'd4},  // R4
    '{CFG_C, 4'b0101, 2'b10, 4'd4},  // R4
    '{CFG_C, 4'b1111, 2'b01, 4'd6}   // R6
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgBit = 1'b0;
  logic       cfgShift = 1'b0;
  logic       cfgCommit = 1'b0;
  logic [3:0] dataIn = '0;
  logic [1:0] dataOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cfg_logic_array dut (
    .clk       (clk),
    .rstN      (rstN),
    .cfgBit    (cfgBit),
    .cfgShift  (cfgShift),
    .cfgCommit (cfgCommit),
    .dataIn    (dataIn),
    .dataOut   (dataOut)
  );

  task automatic checkOut(input logic [3:0] din, input logic [1:0] exp, input string tag);
    dataIn = din;
    #1;
    nChecks++;
    if (dataOut !== exp) begin
      nFails++;
      $display("FAIL %s: in=%b actual=%b expected=%b", tag, din, dataOut, exp);
    end
  endtask

  task automatic loadCfg(input logic [CFGW-1:0] w, input bit doCommit);
    for (int k = CFGW - 1; k >= 0; k--) begin
      @(negedge clk);
      cfgShift = 1'b1;
      cfgBit   = w[k];
    end
    @(negedge clk);
    cfgShift = 1'b0;
    cfgBit   = 1'b0;
    if (doCommit) begin
      cfgCommit = 1'b1;
      @(negedge clk);
      cfgCommit = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [CFGW-1:0] loaded;
    // R1: outputs low during and after reset
    repeat (3) @(negedge clk);
    checkOut(4'b0000, 2'b00, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(4'b1111, 2'b00, "R1 after reset");
    checkOut(4'b0000, 2'b00, "R1 after reset");

    // Table walk, R2 encoding exercised by every load
    loaded = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].cfg != loaded) begin
        loadCfg(VECS[v].cfg, 1'b1);
        loaded = VECS[v].cfg;
      end
      checkOut(VECS[v].din, VECS[v].exp, $sformatf("R%0d table %0d", VECS[v].req, v));
    end

    // R8: conflict row with its input low as well
    loadCfg(CFG_B, 1'b1);
    checkOut(4'b0000, 2'b00, "R8 conflict row, input low");

    // R2: single true switch on input 3 selected onto output 1 only
    loadCfg({10'b0, 10'b0, 10'b0, 10'b00_00_00_10_01}, 1'b1);
    checkOut(4'b1000, 2'b10, "R2 last row field order");
    checkOut(4'b0111, 2'b00, "R2 last row field order");

    // R3: staged string invisible until commit
    loadCfg(CFG_A, 1'b1);
    loadCfg(CFG_B, 1'b0);
    checkOut(4'b0000, 2'b01, "R3 staged not committed");
    @(negedge clk);
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
    checkOut(4'b0000, 2'b00, "R3 after commit");

    // R10: shift and commit in the same cycle
    loadCfg(CFG_A, 1'b0);
    @(negedge clk);
    cfgShift  = 1'b1;
    cfgBit    = 1'b1;
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgShift  = 1'b0;
    cfgBit    = 1'b0;
    cfgCommit = 1'b0;
    checkOut(4'b0000, 2'b01, "R10 pre-shift value committed");
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
    checkOut(4'b0000, 2'b00, "R10 shift still applied");

    // R1: reset in mid operation clears the active string
    loadCfg(CFG_C, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkOut(4'b0011, 2'b00, "R1 mid-run reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(4'b1100, 2'b00, "R1 mid-run reset released");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule